// File: doc/BRIEF.md
# Three-Channel Direct Digital Synthesis Tone Generator

The block produces three independent square-wave or pulse-train outputs from the system clock. Each channel has a 20-bit phase accumulator. On every tick of a prescaled clock, the accumulator adds a programmable tuning word. Each carry out of the accumulator flips a toggle flop. The output frequency is therefore f_clk / ratio × tuning / 2^21, with a frequency step that is set by the tuning word alone.

A small word-addressed register port configures the block. One control word holds a global run bit and a ten-bit settings field for each channel: shape, idle level, pin enable, live level readback, prescaler code and pulse-length code. Three further words hold the tuning words. In pulse mode a channel produces fixed-length active pulses at the same rate that the tuning word sets for the square wave, which gives a variable duty cycle at an unchanged frequency.

Top module: `dds_tone_gen`

## Requirements
- R1: After reset, every register reads 0 and all three pins are 0.
- R2: Address 0 is the control word and addresses 1, 2 and 3 hold the tuning words of channels 0, 1 and 2. A tuning word keeps bits 19:0 and reads 0 above them. In the control word, bit 0 is the run bit and channel c owns bits starting at 1+10c: +0 mode, +1 idle level, +2 pin enable, +3 live level (read-only), +4..+6 prescaler code, +7..+9 pulse code. Bit 31 reads 0.
- R3: In mode 0, each tick adds the tuning word to the accumulator and each carry flips the output, which gives exactly 50% duty. A half period is 2^20/tuning ticks when that ratio is whole, and on average otherwise.
- R4: Prescaler codes 0 to 7 give one tick every 2, 4, 8, 64, 128, 1024, 2048 or 4096 system clocks.
- R5: While the run bit is 0, every accumulator and toggle is cleared, and each pin shows its idle level (when enabled). On a new start the phase begins again from zero.
- R6: With the idle level bit set, the channel output is inverted.
- R7: With the pin enable bit clear, the pin is 0 whatever the other settings.
- R8: The live level bit shows the channel level before the pin enable gate.
- R9: In mode 1, a pulse starts on every second carry, the point where the toggle would go active. The pulse is the inverse of the idle level and lasts 2^(code+1) ticks (code 0..7 gives 2..256). The repetition period equals the mode 0 period.
- R10: If a pulse is longer than the period, each new start restarts it, so the output stays active without a gap.
- R11: A zero tuning word produces no carries and the output rests at idle. A new tuning word takes effect on the next tick without clearing the accumulator.
- R12: The channels run independently, each with its own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| tone_o | output | 3 | Channel output pins |

## Verification
Power-of-two tuning words give whole half periods, so the high and low run lengths can be compared exactly across all eight prescaler codes. A tuning word of 3·2^17 gives uneven carry spacing, and counting its transitions separates a true modular accumulator from a reload counter. In pulse mode, three patterns each expose a different fault: short pulses against a long period check the pulse length, inverted idle checks the active level, and a pulse longer than the period checks the restart. A zero tuning word, the pin enable gate with live readback, the run-bit restart phase and two channels running at once separate a channel's own state from its settings and from the other channels.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int unsigned CTRL_W   = 32;
  localparam int unsigned FLD_W    = 10;
  localparam int unsigned FLD_BASE = 1;
  localparam int unsigned F_MODE   = 0;
  localparam int unsigned F_POL    = 1;
  localparam int unsigned F_OE     = 2;
  localparam int unsigned F_STAT   = 3;
  localparam int unsigned F_PRE    = 4;
  localparam int unsigned F_PLS    = 7;

  typedef struct packed {
    logic [2:0] pls;
    logic [2:0] pre;
    logic       oe;
    logic       pol;
    logic       mode;
  } ch_cfg_t;

  // log2 of the divide ratio for each prescaler code
  function automatic logic [3:0] pre_exp(input logic [2:0] code);
    case (code)
      3'd0:    return 4'd1;
      3'd1:    return 4'd2;
      3'd2:    return 4'd3;
      3'd3:    return 4'd6;
      3'd4:    return 4'd7;
      3'd5:    return 4'd10;
      3'd6:    return 4'd11;
      default: return 4'd12;
    endcase
  endfunction

  // pulse length minus one, in ticks
  function automatic logic [7:0] pls_last(input logic [2:0] code);
    logic [8:0] v;
    v = (9'd2 << code) - 9'd1;
    return v[7:0];
  endfunction
endpackage

// File: rtl/dds_regs.sv
module dds_regs
  import dds_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned ACC_W  = 20,
  parameter int unsigned ADDR_W = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [CTRL_W-1:0]              wdata_i,
  input  logic [NUM_CH-1:0]              lvl_i,
  output logic                           en_o,
  output ch_cfg_t [NUM_CH-1:0]           cfg_o,
  output logic [NUM_CH-1:0][ACC_W-1:0]   tw_o,
  output logic [CTRL_W-1:0]              rdata_o
);
  logic                         en_q;
  ch_cfg_t [NUM_CH-1:0]         cfg_q;
  logic [NUM_CH-1:0][ACC_W-1:0] tw_q;
  logic                         unused_wd;

  assign unused_wd = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cfg_q <= '0;
      tw_q  <= '0;
    end else if (we_i) begin
      if (addr_i == '0) begin
        en_q <= wdata_i[0];
        for (int c = 0; c < int'(NUM_CH); c++) begin
          cfg_q[c].mode <= wdata_i[FLD_BASE + FLD_W*c + F_MODE];
          cfg_q[c].pol  <= wdata_i[FLD_BASE + FLD_W*c + F_POL];
          cfg_q[c].oe   <= wdata_i[FLD_BASE + FLD_W*c + F_OE];
          cfg_q[c].pre  <= wdata_i[FLD_BASE + FLD_W*c + F_PRE +: 3];
          cfg_q[c].pls  <= wdata_i[FLD_BASE + FLD_W*c + F_PLS +: 3];
        end
      end
      for (int c = 0; c < int'(NUM_CH); c++) begin
        if (addr_i == ADDR_W'(c + 1)) tw_q[c] <= wdata_i[ACC_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) begin
      rdata_o[0] = en_q;
      for (int c = 0; c < int'(NUM_CH); c++) begin
        rdata_o[FLD_BASE + FLD_W*c + F_MODE]   = cfg_q[c].mode;
        rdata_o[FLD_BASE + FLD_W*c + F_POL]    = cfg_q[c].pol;
        rdata_o[FLD_BASE + FLD_W*c + F_OE]     = cfg_q[c].oe;
        rdata_o[FLD_BASE + FLD_W*c + F_STAT]   = lvl_i[c];
        rdata_o[FLD_BASE + FLD_W*c + F_PRE +: 3] = cfg_q[c].pre;
        rdata_o[FLD_BASE + FLD_W*c + F_PLS +: 3] = cfg_q[c].pls;
      end
    end
    for (int c = 0; c < int'(NUM_CH); c++) begin
      if (addr_i == ADDR_W'(c + 1)) rdata_o[ACC_W-1:0] = tw_q[c];
    end
  end

  assign en_o  = en_q;
  assign cfg_o = cfg_q;
  assign tw_o  = tw_q;
endmodule

// File: rtl/dds_prescaler.sv
module dds_prescaler #(
  parameter int unsigned PRE_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic [PRE_W-1:0] cnt_o
);
  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
    else            cnt_q <= '0;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dds_channel.sv
module dds_channel
  import dds_pkg::*;
#(
  parameter int unsigned ACC_W = 20,
  parameter int unsigned PRE_W = 12,
  parameter int unsigned PLS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  ch_cfg_t          cfg_i,
  input  logic [ACC_W-1:0] tw_i,
  input  logic [PRE_W-1:0] pre_cnt_i,
  output logic             tick_o,
  output logic [ACC_W-1:0] acc_o,
  output logic             lvl_o
);
  logic [ACC_W-1:0] acc_q;
  logic             tgl_q;
  logic             pact_q;
  logic [PLS_W-1:0] pcnt_q;
  logic [PRE_W-1:0] mask;
  logic [ACC_W:0]   sum;
  logic             tick, carry, start, raw;

  // ratio 4096 wraps the shift to zero, so the mask becomes all ones
  assign mask  = (PRE_W'(1) << pre_exp(cfg_i.pre)) - PRE_W'(1);
  assign tick  = en_i && ((pre_cnt_i & mask) == mask);
  assign sum   = {1'b0, acc_q} + {1'b0, tw_i};
  assign carry = sum[ACC_W];
  assign start = tick && carry && !tgl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tgl_q  <= 1'b0;
      pact_q <= 1'b0;
      pcnt_q <= '0;
    end else if (!en_i) begin
      acc_q  <= '0;
      tgl_q  <= 1'b0;
      pact_q <= 1'b0;
      pcnt_q <= '0;
    end else if (tick) begin
      acc_q <= sum[ACC_W-1:0];
      if (carry) tgl_q <= !tgl_q;
      if (start) begin
        pact_q <= 1'b1;
        pcnt_q <= PLS_W'(pls_last(cfg_i.pls));
      end else if (pact_q) begin
        if (pcnt_q == '0) pact_q <= 1'b0;
        else              pcnt_q <= pcnt_q - 1'b1;
      end
    end
  end

  assign raw    = en_i && (cfg_i.mode ? pact_q : tgl_q);
  assign lvl_o  = raw ^ cfg_i.pol;
  assign tick_o = tick;
  assign acc_o  = acc_q;
endmodule

// File: rtl/dds_tone_gen.sv
module dds_tone_gen
  import dds_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned ACC_W  = 20,
  parameter int unsigned PRE_W  = 12,
  parameter int unsigned PLS_W  = 8,
  localparam int unsigned ADDR_W = $clog2(NUM_CH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CTRL_W-1:0] reg_wdata_i,
  output logic [CTRL_W-1:0] reg_rdata_o,
  output logic [NUM_CH-1:0] tone_o
);
  logic                         glb_en;
  ch_cfg_t [NUM_CH-1:0]         ch_cfg;
  logic [NUM_CH-1:0][ACC_W-1:0] ch_tw;
  logic [NUM_CH-1:0][ACC_W-1:0] ch_acc;
  logic [NUM_CH-1:0]            ch_tick;
  logic [NUM_CH-1:0]            ch_lvl;
  logic [PRE_W-1:0]             pre_cnt;

  dds_regs #(
    .NUM_CH(NUM_CH), .ACC_W(ACC_W), .ADDR_W(ADDR_W)
  ) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .lvl_i   (ch_lvl),
    .en_o    (glb_en),
    .cfg_o   (ch_cfg),
    .tw_o    (ch_tw),
    .rdata_o (reg_rdata_o)
  );

  dds_prescaler #(.PRE_W(PRE_W)) i_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (glb_en),
    .cnt_o  (pre_cnt)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dds_channel #(
      .ACC_W(ACC_W), .PRE_W(PRE_W), .PLS_W(PLS_W)
    ) i_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (glb_en),
      .cfg_i     (ch_cfg[c]),
      .tw_i      (ch_tw[c]),
      .pre_cnt_i (pre_cnt),
      .tick_o    (ch_tick[c]),
      .acc_o     (ch_acc[c]),
      .lvl_o     (ch_lvl[c])
    );
    assign tone_o[c] = ch_cfg[c].oe & ch_lvl[c];
  end
endmodule

// File: rtl/dds_tone_gen_chk.sv
module dds_tone_gen_chk
  import dds_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned ACC_W  = 20
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         en_i,
  input ch_cfg_t [NUM_CH-1:0]         cfg_i,
  input logic [NUM_CH-1:0][ACC_W-1:0] tw_i,
  input logic [NUM_CH-1:0][ACC_W-1:0] acc_i,
  input logic [NUM_CH-1:0]            tick_i,
  input logic [NUM_CH-1:0]            tone_i
);
  logic unused_cfg;
  assign unused_cfg = ^cfg_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    a_r5_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |-> tone_i[c] == (cfg_i[c].oe & cfg_i[c].pol));

    a_r5_acc_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> acc_i[c] == '0);

    a_r7_oe_forces_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_i[c].oe |-> !tone_i[c]);

    a_r11_zero_tw_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i && $past(en_i) && (tw_i[c] == '0) && ($past(tw_i[c]) == '0)
      |-> acc_i[c] == $past(acc_i[c]));

    a_r3_acc_only_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i && $past(en_i) && !$past(tick_i[c]) |-> $stable(acc_i[c]));

    a_r4_no_back_to_back_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i[c] |=> !tick_i[c]);
  end
endmodule

bind dds_tone_gen dds_tone_gen_chk #(.NUM_CH(NUM_CH), .ACC_W(ACC_W)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (glb_en),
  .cfg_i  (ch_cfg),
  .tw_i   (ch_tw),
  .acc_i  (ch_acc),
  .tick_i (ch_tick),
  .tone_i (tone_o)
);

// File: tb/test_dds_tone_gen.sv
module test_dds_tone_gen;
  localparam int CLK_PERIOD = 10;
  localparam int LIM        = 20000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  tone;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_tone_gen i_dds_tone_gen (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tone_o(tone)
  );

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
    addr = '0;
  endtask

  function automatic logic [31:0] fld(input int ch, input bit mode, input bit pol, input bit oe,
                                      input logic [2:0] pre, input logic [2:0] pls);
    logic [9:0] f;
    f = {pls, pre, 1'b0, oe, pol, mode};
    return 32'(f) << (1 + 10*ch);
  endfunction

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(input int ch, output int hi, output int lo);
    int n;
    n = 0;
    while (tone[ch] !== 1'b0 && n < LIM) begin @(negedge clk); n++; end
    n = 0;
    while (tone[ch] !== 1'b1 && n < LIM) begin @(negedge clk); n++; end
    hi = 0;
    while (tone[ch] === 1'b1 && hi < LIM) begin @(negedge clk); hi++; end
    lo = 0;
    while (tone[ch] === 1'b0 && lo < LIM) begin @(negedge clk); lo++; end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1", "pins after reset", tone, 0);
    reg_rd(2'd0, d); chk("R1", "control after reset", d, 0);
    reg_rd(2'd3, d); chk("R1", "tuning ch2 after reset", d, 0);
  endtask

  task automatic t_readback();
    logic [31:0] w, e, d;
    w = fld(0, 1, 1, 0, 3'd5, 3'd3) | fld(1, 0, 0, 1, 3'd2, 3'd7) | fld(2, 1, 0, 1, 3'd7, 3'd0);
    e = w | (32'd1 << 4);                 // ch0 live bit shows idle high
    reg_wr(2'd0, w | (32'd1 << 14) | (32'd1 << 31));
    reg_rd(2'd0, d); chk("R2", "control readback", d, e);
    reg_wr(2'd2, 32'hFFFF_FFFF);
    reg_rd(2'd2, d); chk("R2", "tuning width", d, 32'h000F_FFFF);
    reg_rd(2'd1, d); chk("R2", "tuning ch0 untouched", d, 0);
    reg_wr(2'd0, 0);
    reg_wr(2'd2, 0);
  endtask

  task automatic t_standard();
    int hi, lo;
    reg_wr(2'd1, 32'h4_0000);
    reg_wr(2'd0, 1 | fld(0, 0, 0, 1, 3'd0, 3'd0));
    measure(0, hi, lo);
    chk("R3", "high run tw=2^18", hi, 8); chk("R3", "low run tw=2^18", lo, 8);
    reg_wr(2'd1, 32'h1_0000);
    measure(0, hi, lo);
    chk("R3", "high run tw=2^16", hi, 32); chk("R3", "low run tw=2^16", lo, 32);
    reg_wr(2'd0, 0);
  endtask

  task automatic t_fraction();
    int tr; logic prev;
    reg_wr(2'd1, 32'h6_0000);
    reg_wr(2'd0, 1 | fld(0, 0, 0, 1, 3'd0, 3'd0));
    prev = tone[0]; tr = 0;
    for (int i = 0; i < 1600; i++) begin
      @(negedge clk);
      if (tone[0] !== prev) tr++;
      prev = tone[0];
    end
    chk("R3", "transitions tw=3*2^17 within 1", (tr >= 299 && tr <= 301), 1);
    reg_wr(2'd0, 0);
  endtask

  task automatic t_prescale();
    int ratio[8] = '{2, 4, 8, 64, 128, 1024, 2048, 4096};
    int hi, lo;
    reg_wr(2'd2, 32'h8_0000);
    for (int k = 0; k < 8; k++) begin
      reg_wr(2'd0, 1 | fld(1, 0, 0, 1, 3'(k), 3'd0));
      measure(1, hi, lo);
      chk("R4", $sformatf("high run code %0d", k), hi, 2*ratio[k]);
      chk("R4", $sformatf("low run code %0d", k), lo, 2*ratio[k]);
      reg_wr(2'd0, 0);
    end
    reg_wr(2'd2, 0);
  endtask

  task automatic t_polarity();
    reg_wr(2'd3, 32'h4_0000);
    reg_wr(2'd0, fld(2, 0, 1, 1, 3'd0, 3'd0));
    wait_cyc(2);
    chk("R5", "stopped pin at idle high", tone[2], 1);
    reg_wr(2'd0, 1 | fld(2, 0, 1, 1, 3'd0, 3'd0));
    chk("R6", "inverted start level", tone[2], 1);
    wait_cyc(10);
    chk("R6", "inverted after first carry", tone[2], 0);
    reg_wr(2'd0, fld(2, 0, 1, 1, 3'd0, 3'd0));
    wait_cyc(3);
    chk("R5", "idle after stop", tone[2], 1);
    reg_wr(2'd0, 1 | fld(2, 0, 1, 1, 3'd0, 3'd0));
    wait_cyc(5);
    chk("R5", "phase restarts from zero (before carry)", tone[2], 1);
    wait_cyc(5);
    chk("R5", "phase restarts from zero (after carry)", tone[2], 0);
    reg_wr(2'd0, 0);
    reg_wr(2'd3, 0);
  endtask

  task automatic t_oe_status();
    logic [31:0] d; int st_tr, pin_hi; logic prev;
    reg_wr(2'd0, 1 | fld(0, 0, 1, 0, 3'd0, 3'd0));
    chk("R7", "pin gated with idle high", tone[0], 0);
    reg_rd(2'd0, d); chk("R8", "live bit idle high", d[4], 1);
    reg_wr(2'd0, 1 | fld(0, 0, 1, 1, 3'd0, 3'd0));
    chk("R7", "pin follows when enabled", tone[0], 1);
    reg_wr(2'd1, 32'h4_0000);
    reg_wr(2'd0, 1 | fld(0, 0, 0, 0, 3'd0, 3'd0));
    st_tr = 0; pin_hi = 0; prev = 1'b0;
    for (int i = 0; i < 40; i++) begin
      reg_rd(2'd0, d);
      if (d[4] !== prev) st_tr++;
      prev = d[4];
      if (tone[0] !== 1'b0) pin_hi++;
    end
    chk("R7", "pin high samples while gated", pin_hi, 0);
    chk("R8", "live bit toggles while gated", st_tr >= 4, 1);
    reg_wr(2'd0, 0);
    reg_wr(2'd1, 0);
  endtask

  task automatic t_pulse();
    int hi, lo;
    reg_wr(2'd1, 32'h2_0000);
    reg_wr(2'd0, 1 | fld(0, 1, 0, 1, 3'd0, 3'd0));
    measure(0, hi, lo);
    chk("R9", "pulse code 0 high", hi, 4); chk("R9", "pulse code 0 low", lo, 28);
    reg_wr(2'd0, 0);
    reg_wr(2'd0, 1 | fld(0, 1, 0, 1, 3'd0, 3'd1));
    measure(0, hi, lo);
    chk("R9", "pulse code 1 high", hi, 8); chk("R9", "pulse code 1 low", lo, 24);
    reg_wr(2'd0, 0);
    reg_wr(2'd0, 1 | fld(0, 1, 1, 1, 3'd0, 3'd0));
    measure(0, hi, lo);
    chk("R9", "active-low pulse high", hi, 28); chk("R9", "active-low pulse low", lo, 4);
    reg_wr(2'd0, 0);
  endtask

  task automatic t_restart();
    int n, ones;
    reg_wr(2'd1, 32'h8_0000);
    reg_wr(2'd0, 1 | fld(0, 1, 0, 1, 3'd0, 3'd7));
    n = 0;
    while (tone[0] !== 1'b1 && n < LIM) begin @(negedge clk); n++; end
    ones = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (tone[0] === 1'b1) ones++;
    end
    chk("R10", "long pulse stays active", ones, 200);
    reg_wr(2'd0, 0);
  endtask

  task automatic t_zero_tw();
    int tr, hi, lo;
    reg_wr(2'd1, 0);
    reg_wr(2'd0, 1 | fld(0, 0, 0, 1, 3'd0, 3'd0));
    tr = 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (tone[0] !== 1'b0) tr++;
    end
    chk("R11", "zero tuning word stays idle", tr, 0);
    reg_wr(2'd1, 32'h8_0000);
    measure(0, hi, lo);
    chk("R11", "new tuning word high run", hi, 4);
    chk("R11", "new tuning word low run", lo, 4);
    reg_wr(2'd0, 0);
    reg_wr(2'd1, 0);
  endtask

  task automatic t_indep();
    int hi, lo, bad1;
    reg_wr(2'd1, 32'h4_0000);
    reg_wr(2'd3, 32'h4_0000);
    reg_wr(2'd0, 1 | fld(0, 0, 0, 1, 3'd0, 3'd0) | fld(1, 0, 0, 1, 3'd0, 3'd0)
                   | fld(2, 0, 0, 1, 3'd1, 3'd0));
    measure(0, hi, lo);
    chk("R12", "ch0 high run", hi, 8);
    measure(2, hi, lo);
    chk("R12", "ch2 high run", hi, 16); chk("R12", "ch2 low run", lo, 16);
    bad1 = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (tone[1] !== 1'b0) bad1++;
    end
    chk("R12", "ch1 with zero word stays low", bad1, 0);
    reg_wr(2'd0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    wait_cyc(4);
    rst_ni = 1'b1;
    wait_cyc(2);
    t_reset();
    t_readback();
    t_standard();
    t_fraction();
    t_prescale();
    t_polarity();
    t_oe_status();
    t_pulse();
    t_restart();
    t_zero_tw();
    t_indep();
    summary();
  end
endmodule